// File: doc/BRIEF.md
# SPI Slave Transmitter with Selectable Underrun Policy

This block is the transmit side of a mode-0 SPI slave. Local logic pushes bytes through a write port into a small transmit queue, and the block shifts them out MSB first on the slave data output while the master holds chip select low. SCK and chip select come from the master asynchronously. They are brought into the system clock through a synchronizer, and all shifting is done from the detected edges.

The block's main concern is what the master reads after the queued data is used up, because the master may keep clocking. A two-bit policy input sets that behaviour. The block can resend the last frame it transmitted, send the oldest byte still held in queue storage even though it was already consumed, or send zeros. A byte is committed, and popped from the queue, only when its first bit is sampled. A byte written after a frame has been set up waits for the next frame and never disturbs the bit already on the line. A sticky flag reports each clocked frame that had no fresh data.

Top module: `spi_underrun_tx`

## Requirements
- R1: After reset the queue reports empty and not full, the underrun flag is 0, and the data output is not driven (enable 0, line at high impedance).
- R2: Bytes leave in the order they were written. Each byte is sent MSB first. A new bit appears after each SCK falling edge, and the master samples it on the rising edge (mode 0).
- R3: The queue holds 4 bytes. The full flag rises after the fourth unread write, and a write while full is dropped: the dropped byte is never transmitted.
- R4: With policy 2'b00 (repeat), a frame that starts with the queue empty resends the last committed frame. Every further starved frame does the same.
- R5: With policy 2'b01 (replay), a starved frame sends the byte in the queue slot that the next write would overwrite. That is the oldest consumed entry, and it is not popped.
- R6: With policy 2'b10, and also with 2'b11, every starved frame sends 0x00.
- R7: A byte written after a frame has been loaded does not change that frame, including its MSB. It is sent in the following frame.
- R8: After the real data, writing 4 zero bytes makes every later starved frame 0x00 under the repeat and replay policies.
- R9: When chip select rises in the middle of a frame, the partial frame is dropped and the output returns to high impedance. If its first bit was sampled, the byte counts as consumed. The next selection starts a fresh frame from the queue.
- R10: The underrun flag is set when the first bit of a starved frame is sampled. It stays set until a clear pulse, and frames that carry queued data never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the transmit queue |
| wr_data | input | 8 | Byte to queue |
| policy | input | 2 | Underrun policy: 00 repeat, 01 replay, 10/11 zero |
| ur_clr | input | 1 | Clears the sticky underrun flag |
| sck | input | 1 | Serial clock from the master, idles low |
| cs_n | input | 1 | Chip select from the master, active low |
| miso | output | 1 | Serial data to the master, high impedance when not selected |
| miso_oe | output | 1 | High while the data output is driven |
| tx_full | output | 1 | Queue full |
| tx_empty | output | 1 | Queue empty |
| underrun | output | 1 | Sticky starved-frame flag |

## Verification
Distinct byte patterns such as 0x3C, 0xA5 and 0x0F are sent in a single burst, which exposes bit-order and byte-order errors. Each underrun policy is then run past the end of the data. A repeated last byte, a replayed slot chosen by the wrapped write pointer, and zeros all differ on the wire, so a mix-up between policies shows up. A late write into a frame already loaded as zero checks that the frame is held and the byte deferred. A burst cut short by chip select, and zero-padding under repeat and replay, check the pop-on-first-bit rule and the flush behaviour.

// File: rtl/spi_utx_pkg.sv
package spi_utx_pkg;

    localparam int FRAME_W = 8;
    localparam int CNT_W   = $clog2(FRAME_W);

    typedef enum logic [1:0] {
        POL_REPEAT   = 2'b00,
        POL_REPLAY   = 2'b01,
        POL_ZERO     = 2'b10,
        POL_ZERO_ALT = 2'b11
    } ur_policy_e;

    typedef logic [FRAME_W-1:0] frame_t;

    // Byte placed on the line when a frame starts with nothing queued
    function automatic frame_t starved_byte(ur_policy_e pol, frame_t last_b, frame_t stale_b);
        frame_t r;
        case (pol)
            POL_REPEAT: r = last_b;
            POL_REPLAY: r = stale_b;
            default:    r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spi_utx_sync.sv
module spi_utx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_in,
    input  logic csn_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic cs_start
);
    localparam int PW = STAGES + 1;

    logic [PW-1:0] sck_pipe;
    logic [PW-1:0] csn_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_pipe <= '0;
            csn_pipe <= '1;
        end else begin
            sck_pipe <= {sck_pipe[PW-2:0], sck_in};
            csn_pipe <= {csn_pipe[PW-2:0], csn_in};
        end
    end

    // Edges are taken between the last synchronizer stage and one more flop
    assign sck_rise = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
    assign sck_fall = ~sck_pipe[STAGES-1] & sck_pipe[STAGES];
    assign cs_act   = ~csn_pipe[STAGES-1];
    assign cs_start = ~csn_pipe[STAGES-1] & csn_pipe[STAGES];

endmodule

// File: rtl/spi_utx_fifo.sv
module spi_utx_fifo
    import spi_utx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  frame_t wr_data,
    input  logic   pop,
    output frame_t head,
    output logic   full,
    output logic   empty
);
    localparam int AW = $clog2(DEPTH);

    frame_t        mem [DEPTH];
    logic [AW:0]   wr_q;
    logic [AW:0]   rd_q;
    logic          accept;

    assign full   = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
    assign empty  = (wr_q == rd_q);
    assign accept = wr_en && !full;
    // When empty, the read slot is the one the next write overwrites: the oldest consumed entry
    assign head   = mem[rd_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= '0;
            rd_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (accept) begin
                mem[wr_q[AW-1:0]] <= wr_data;
                wr_q <= wr_q + 1'b1;
            end
            if (pop && !empty) rd_q <= rd_q + 1'b1;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> (wr_q == $past(wr_q)));

    assert_pop_valid_R2: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/spi_utx_shifter.sv
module spi_utx_shifter
    import spi_utx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       cs_act,
    input  logic       cs_start,
    input  ur_policy_e policy,
    input  frame_t     q_head,
    input  logic       q_empty,
    output logic       pop,
    output logic       starve_hit,
    output logic       tx_bit
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    frame_t          shreg;
    frame_t          last_q;
    logic [CNT_W-1:0] bit_q;
    logic            pend_q;
    logic            src_q;
    logic            starve_q;
    logic            load_now;
    logic            commit;
    frame_t          load_val;

    assign load_now = cs_start || (cs_act && sck_fall && pend_q);
    assign load_val = q_empty ? starved_byte(policy, last_q, q_head) : q_head;
    assign commit   = cs_act && !load_now && sck_rise && (bit_q == '0);
    assign pop        = commit && src_q;
    assign starve_hit = commit && starve_q;
    assign tx_bit     = shreg[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            last_q   <= '0;
            bit_q    <= '0;
            pend_q   <= 1'b0;
            src_q    <= 1'b0;
            starve_q <= 1'b0;
        end else if (!cs_act) begin
            bit_q    <= '0;
            pend_q   <= 1'b0;
            src_q    <= 1'b0;
            starve_q <= 1'b0;
        end else if (load_now) begin
            shreg    <= load_val;
            src_q    <= !q_empty;
            starve_q <= q_empty;
            bit_q    <= '0;
            pend_q   <= 1'b0;
        end else if (sck_rise) begin
            if (bit_q == '0) begin
                last_q   <= shreg;
                src_q    <= 1'b0;
                starve_q <= 1'b0;
            end
            if (bit_q == LAST_BIT) begin
                bit_q  <= '0;
                pend_q <= 1'b1;
            end else begin
                bit_q <= bit_q + 1'b1;
            end
        end else if (sck_fall) begin
            shreg <= {shreg[FRAME_W-2:0], 1'b0};
        end
    end

    assert_zero_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (load_now && q_empty && (policy == POL_ZERO || policy == POL_ZERO_ALT)) |=> (shreg == '0));

    assert_msb_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (cs_act && !sck_fall && !cs_start) |=> (tx_bit == $past(tx_bit)));

    assert_abort_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_act) |=> (bit_q == '0 && !pend_q));

endmodule

// File: rtl/spi_underrun_tx.sv
module spi_underrun_tx
    import spi_utx_pkg::*;
#(
    parameter int DEPTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic [1:0]         policy,
    input  logic               ur_clr,
    input  logic               sck,
    input  logic               cs_n,
    output logic               miso,
    output logic               miso_oe,
    output logic               tx_full,
    output logic               tx_empty,
    output logic               underrun
);
    logic   sck_rise, sck_fall, cs_act, cs_start;
    logic   pop, starve_hit, tx_bit;
    frame_t q_head;
    logic   underrun_q;

    spi_utx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sck_in   (sck),
        .csn_in   (cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_act   (cs_act),
        .cs_start (cs_start)
    );

    spi_utx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (pop),
        .head    (q_head),
        .full    (tx_full),
        .empty   (tx_empty)
    );

    spi_utx_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .cs_act     (cs_act),
        .cs_start   (cs_start),
        .policy     (ur_policy_e'(policy)),
        .q_head     (q_head),
        .q_empty    (tx_empty),
        .pop        (pop),
        .starve_hit (starve_hit),
        .tx_bit     (tx_bit)
    );

    always_ff @(posedge clk) begin
        if (rst)             underrun_q <= 1'b0;
        else if (starve_hit) underrun_q <= 1'b1;
        else if (ur_clr)     underrun_q <= 1'b0;
    end

    assign underrun = underrun_q;
    assign miso_oe  = cs_act;
    assign miso     = cs_act ? tx_bit : 1'bz;

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (underrun_q && !ur_clr) |=> underrun_q);

    assert_flag_source_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun_q) |-> $past(starve_hit));

endmodule

// File: tb/spi_underrun_tx_bench.sv
module spi_underrun_tx_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [1:0] policy;
    logic       ur_clr;
    logic       sck;
    logic       cs_n;
    wire        miso;
    logic       miso_oe, tx_full, tx_empty, underrun;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    spi_underrun_tx u_spi_underrun_tx (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .policy(policy),
        .ur_clr(ur_clr), .sck(sck), .cs_n(cs_n), .miso(miso), .miso_oe(miso_oe),
        .tx_full(tx_full), .tx_empty(tx_empty), .underrun(underrun)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] pol);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; ur_clr = 1'b0;
        sck = 1'b0; cs_n = 1'b1; policy = pol;
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cs_begin;
        @(negedge clk); cs_n = 1'b0; wait_n(8);
    endtask

    task automatic cs_end;
        @(negedge clk); cs_n = 1'b1; wait_n(8);
    endtask

    task automatic clock_bits(input int n, output logic [7:0] v);
        v = '0;
        for (int b = 0; b < n; b++) begin
            v[7-b] = miso;
            sck = 1'b1; wait_n(8);
            sck = 1'b0; wait_n(8);
        end
    endtask

    task automatic expect_frame(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        clock_bits(8, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset;
        do_reset(2'b00);
        chk("R1 empty", {7'd0, tx_empty}, 8'd1);
        chk("R1 full", {7'd0, tx_full}, 8'd0);
        chk("R1 underrun", {7'd0, underrun}, 8'd0);
        chk("R1 oe", {7'd0, miso_oe}, 8'd0);
        chk("R1 hiz", {7'd0, miso}, {7'd0, 1'bz});
    endtask

    task automatic t_order;
        do_reset(2'b00);
        push(8'h3C); push(8'hA5); push(8'h0F);
        cs_begin;
        expect_frame("R2 byte0", 8'h3C);
        expect_frame("R2 byte1", 8'hA5);
        expect_frame("R2 byte2", 8'h0F);
        cs_end;
        chk("R10 no flag on data", {7'd0, underrun}, 8'd0);
        chk("R2 drained", {7'd0, tx_empty}, 8'd1);
    endtask

    task automatic t_full_repeat;
        do_reset(2'b00);
        push(8'h11); push(8'h22); push(8'h33);
        chk("R3 not full at 3", {7'd0, tx_full}, 8'd0);
        push(8'h44);
        chk("R3 full at 4", {7'd0, tx_full}, 8'd1);
        push(8'h55);
        cs_begin;
        expect_frame("R3 d0", 8'h11);
        expect_frame("R3 d1", 8'h22);
        expect_frame("R3 d2", 8'h33);
        expect_frame("R3 d3", 8'h44);
        expect_frame("R3 dropped byte absent / R4 repeat", 8'h44);
        expect_frame("R4 repeat again", 8'h44);
        cs_end;
        chk("R10 flag set", {7'd0, underrun}, 8'd1);
        wait_n(20);
        chk("R10 flag sticky", {7'd0, underrun}, 8'd1);
        @(negedge clk); ur_clr = 1'b1; @(negedge clk); ur_clr = 1'b0;
        wait_n(2);
        chk("R10 flag cleared", {7'd0, underrun}, 8'd0);
    endtask

    task automatic t_replay;
        do_reset(2'b01);
        push(8'hA1); push(8'hB2); push(8'hC3); push(8'hD4);
        cs_begin;
        expect_frame("R5 a", 8'hA1);
        expect_frame("R5 b", 8'hB2);
        expect_frame("R5 c", 8'hC3);
        expect_frame("R5 d", 8'hD4);
        expect_frame("R5 stale slot0", 8'hA1);
        cs_end;
        push(8'hE5); push(8'hF6);
        cs_begin;
        expect_frame("R5 e", 8'hE5);
        expect_frame("R5 f", 8'hF6);
        expect_frame("R5 stale slot2", 8'hC3);
        expect_frame("R5 stale slot2 again", 8'hC3);
        cs_end;
    endtask

    task automatic t_zero;
        do_reset(2'b10);
        push(8'h77);
        cs_begin;
        expect_frame("R6 data", 8'h77);
        expect_frame("R6 zero 10", 8'h00);
        expect_frame("R6 zero 10 again", 8'h00);
        cs_end;
        policy = 2'b11;
        cs_begin;
        expect_frame("R6 zero 11", 8'h00);
        cs_end;
    endtask

    task automatic t_hold;
        do_reset(2'b10);
        cs_begin;
        push(8'hFF);
        expect_frame("R7 loaded frame unchanged", 8'h00);
        expect_frame("R7 late byte next frame", 8'hFF);
        cs_end;
        chk("R10 starved frame flagged", {7'd0, underrun}, 8'd1);
    endtask

    task automatic t_flush;
        do_reset(2'b00);
        push(8'h9A);
        for (int i = 0; i < 4; i++) push(8'h00);
        cs_begin;
        expect_frame("R8 repeat data", 8'h9A);
        for (int i = 0; i < 4; i++) expect_frame("R8 repeat pad", 8'h00);
        expect_frame("R8 repeat starved", 8'h00);
        cs_end;
        do_reset(2'b01);
        push(8'h12); push(8'h34); push(8'h56); push(8'h78);
        cs_begin;
        for (int i = 0; i < 4; i++) expect_frame("R8 replay data", 8'h12 + 8'(i) * 8'h22);
        cs_end;
        for (int i = 0; i < 4; i++) push(8'h00);
        cs_begin;
        for (int i = 0; i < 4; i++) expect_frame("R8 replay pad", 8'h00);
        expect_frame("R8 replay starved", 8'h00);
        expect_frame("R8 replay starved again", 8'h00);
        cs_end;
    endtask

    task automatic t_abort;
        logic [7:0] v;
        do_reset(2'b00);
        push(8'h5A); push(8'hC3);
        cs_begin;
        clock_bits(3, v);
        chk("R9 partial bits", v, 8'h40);
        @(negedge clk); cs_n = 1'b1; wait_n(8);
        chk("R9 oe low", {7'd0, miso_oe}, 8'd0);
        chk("R9 hiz", {7'd0, miso}, {7'd0, 1'bz});
        cs_begin;
        expect_frame("R9 fresh frame", 8'hC3);
        cs_end;
        chk("R9 no underrun", {7'd0, underrun}, 8'd0);
    endtask

    initial begin
        t_reset;
        t_order;
        t_full_repeat;
        t_replay;
        t_zero;
        t_hold;
        t_flush;
        t_abort;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule